// File: doc/BRIEF.md
# 64-bit Exception Entry Unit

This block performs the state change needed to enter a 64-bit exception handler. It takes the current program counter, the current processor state word, a target exception level, an exception kind (synchronous, IRQ, FIQ or SError), the vector base address, the system control register and a flag that says whether memory tagging is implemented. When the one-cycle `take` strobe is high at a rising clock edge, four registers load in the same edge: the link address, the saved state word, the handler state word and the handler program counter.

The handler address is the vector base plus a group offset plus a kind offset. The group depends on how the source mode compares with the target mode. The handler state word is assembled field by field. Some fields pass through from the old word, some are forced to constants and some come from system control bits. The target is always a privileged level that runs on its own stack pointer.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all four outputs are cleared to zero.
- R2: At a rising edge where `take` is low and `rst` is low, all four outputs keep their values.
- R3: On a take, `link_pc` loads `cur_pc` and `saved_psw` loads `cur_psw` unchanged.
- R4: The group offset is chosen from the source mode bits `cur_psw[4:0]` compared with the target code `{0, tgt_el, 0, 1}`. If they are equal, the offset is 0x200 (current level, own stack). If they differ only in bit 0, it is 0x000 (current level, level-0 stack). Otherwise it is 0x400 when `cur_psw[4]` is 0 and 0x600 when `cur_psw[4]` is 1.
- R5: On a take, `next_pc` = `vbar` + group offset + kind offset. The kind offset is 0x000 for `exc_kind`=0 (synchronous), 0x080 for 1 (IRQ), 0x100 for 2 (FIQ) and 0x180 for 3 (SError).
- R6: On a take, `next_psw` bits 31, 30, 29 and 28 (N, Z, C, V) and bit 24 (DIT) equal the same bits of `cur_psw`.
- R7: On a take, `next_psw` bit 25 (tag-check override) equals `mte_present`.
- R8: On a take, `next_psw` bit 22 (PAN) is `cur_psw[22]` OR NOT `sctlr[23]`.
- R9: On a take, `next_psw` bit 12 (SSBS) equals `sctlr[44]`. Bits 23 (UAO), 21 (SS), 20 (IL) and 11:10 (BTYPE) are zero, and so are all bit positions not named in R6 to R10.
- R10: On a take, `next_psw` bits 9:6 (D, A, I, F) are all 1, bit 4 is 0 and bits 3:0 are `{tgt_el, 0, 1}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take | input | 1 | One-cycle strobe that commits an exception entry |
| cur_pc | input | 64 | Program counter at the faulting point |
| cur_psw | input | 32 | Processor state word before entry |
| tgt_el | input | 2 | Target exception level |
| exc_kind | input | 2 | 0 sync, 1 IRQ, 2 FIQ, 3 SError |
| vbar | input | 64 | Vector table base address |
| sctlr | input | 64 | System control register of the target level |
| mte_present | input | 1 | Memory tagging is implemented |
| link_pc | output | 64 | Return address register |
| saved_psw | output | 32 | Saved copy of the old state word |
| next_psw | output | 32 | State word for the handler |
| next_pc | output | 64 | Handler entry address |

## Verification
Vector group selection and state word reconstruction both read the same old state word in the same take cycle. They fall together when one entry follows another. The bench provokes this by feeding `next_psw` and `next_pc` back into `cur_psw` and `cur_pc` and asserting `take` on consecutive edges, sometimes changing `tgt_el` between them. The own-stack group choice then depends on mode bits that the previous entry wrote, and PAN depends on the previous PAN together with the current SPAN bit. Each edge is judged against a behavioural model that recomputes the expected address and every state field from the requirements.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int PSW_W = 32;

    typedef enum logic [1:0] {
        EXC_SYNC  = 2'd0,
        EXC_IRQ   = 2'd1,
        EXC_FIQ   = 2'd2,
        EXC_SERR  = 2'd3
    } exc_kind_e;

    typedef enum logic [1:0] {
        GRP_CUR_SP0 = 2'd0,
        GRP_CUR_SPX = 2'd1,
        GRP_LOW_64  = 2'd2,
        GRP_LOW_32  = 2'd3
    } vec_group_e;

    // State word, most significant field first
    typedef struct packed {
        logic       n;
        logic       z;
        logic       c;
        logic       v;
        logic [1:0] rsv_hi;
        logic       tco;
        logic       dit;
        logic       uao;
        logic       pan;
        logic       ss;
        logic       il;
        logic [6:0] rsv_mid;
        logic       ssbs;
        logic [1:0] btype;
        logic       d;
        logic       a;
        logic       i;
        logic       f;
        logic       rsv_lo;
        logic       aa32;
        logic [3:0] m;
    } psw_t;

    localparam int GRP_SHIFT  = 9;
    localparam int KIND_SHIFT = 7;
    localparam int VOFF_W     = GRP_SHIFT + 2;

    function automatic logic [4:0] target_mode_code(input logic [1:0] el);
        return {1'b0, el, 1'b0, 1'b1};
    endfunction

    function automatic logic [VOFF_W-1:0] vec_offset(input vec_group_e g,
                                                     input exc_kind_e k);
        logic [VOFF_W-1:0] o;
        o = '0;
        o[GRP_SHIFT +: 2]  = g;
        o[KIND_SHIFT +: 2] = k;
        return o;
    endfunction

endpackage

// File: rtl/exc_vec_group_sel.sv
module exc_vec_group_sel
    import exc_entry_pkg::*;
(
    input  logic [4:0]  src_mode,
    input  logic [1:0]  tgt_el,
    output vec_group_e  group
);
    logic [4:0] tgt_code;

    always_comb begin
        tgt_code = target_mode_code(tgt_el);
        if (src_mode == tgt_code)
            group = GRP_CUR_SPX;
        else if ((src_mode | 5'b00001) == tgt_code)
            group = GRP_CUR_SP0;
        else if (!src_mode[4])
            group = GRP_LOW_64;
        else
            group = GRP_LOW_32;
    end
endmodule

// File: rtl/exc_psw_build.sv
module exc_psw_build
    import exc_entry_pkg::*;
#(
    parameter int SCTLR_W   = 64,
    parameter int SPAN_BIT  = 23,
    parameter int DSSBS_BIT = 44
) (
    input  psw_t               old_psw,
    input  logic [SCTLR_W-1:0] sctlr,
    input  logic               mte_present,
    input  logic [1:0]         tgt_el,
    output psw_t               new_psw
);
    always_comb begin
        new_psw       = '0;
        new_psw.n     = old_psw.n;
        new_psw.z     = old_psw.z;
        new_psw.c     = old_psw.c;
        new_psw.v     = old_psw.v;
        new_psw.dit   = old_psw.dit;
        new_psw.tco   = mte_present;
        new_psw.pan   = old_psw.pan | ~sctlr[SPAN_BIT];
        new_psw.ssbs  = sctlr[DSSBS_BIT];
        new_psw.d     = 1'b1;
        new_psw.a     = 1'b1;
        new_psw.i     = 1'b1;
        new_psw.f     = 1'b1;
        new_psw.aa32  = 1'b0;
        new_psw.m     = target_mode_code(tgt_el)[3:0];
    end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] vbar,
    input  vec_group_e      group,
    input  exc_kind_e       kind,
    output logic [XLEN-1:0] handler_pc
);
    logic [VOFF_W-1:0] off;

    always_comb begin
        off        = vec_offset(group, kind);
        handler_pc = vbar + XLEN'(off);
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int SCTLR_W   = 64,
    parameter int SPAN_BIT  = 23,
    parameter int DSSBS_BIT = 44
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [PSW_W-1:0]   cur_psw,
    input  logic [1:0]         tgt_el,
    input  logic [1:0]         exc_kind,
    input  logic [XLEN-1:0]    vbar,
    input  logic [SCTLR_W-1:0] sctlr,
    input  logic               mte_present,
    output logic [XLEN-1:0]    link_pc,
    output logic [PSW_W-1:0]   saved_psw,
    output logic [PSW_W-1:0]   next_psw,
    output logic [XLEN-1:0]    next_pc
);
    vec_group_e       grp;
    psw_t             built_psw;
    logic [XLEN-1:0]  built_pc;
    exc_kind_e        kind;

    assign kind = exc_kind_e'(exc_kind);

    exc_vec_group_sel u_grp (
        .src_mode (cur_psw[4:0]),
        .tgt_el   (tgt_el),
        .group    (grp)
    );

    exc_psw_build #(
        .SCTLR_W   (SCTLR_W),
        .SPAN_BIT  (SPAN_BIT),
        .DSSBS_BIT (DSSBS_BIT)
    ) u_psw (
        .old_psw     (psw_t'(cur_psw)),
        .sctlr       (sctlr),
        .mte_present (mte_present),
        .tgt_el      (tgt_el),
        .new_psw     (built_psw)
    );

    exc_vec_addr #(.XLEN(XLEN)) u_addr (
        .vbar       (vbar),
        .group      (grp),
        .kind       (kind),
        .handler_pc (built_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            link_pc   <= '0;
            saved_psw <= '0;
            next_psw  <= '0;
            next_pc   <= '0;
        end else if (take) begin
            link_pc   <= cur_pc;
            saved_psw <= cur_psw;
            next_psw  <= built_psw;
            next_pc   <= built_pc;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(link_pc) && $stable(saved_psw) &&
                   $stable(next_psw) && $stable(next_pc)));

    assert_link_R3: assert property (@(posedge clk) disable iff (rst)
        take |=> (link_pc == $past(cur_pc) && saved_psw == $past(cur_psw)));

    assert_align_R5: assert property (@(posedge clk) disable iff (rst)
        take |=> (next_pc[6:0] == $past(vbar[6:0])));

    assert_pan_R8: assert property (@(posedge clk) disable iff (rst)
        (take && !sctlr[SPAN_BIT]) |=> next_psw[22]);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        take |=> (next_psw[23] == 1'b0 && next_psw[21:20] == 2'b00 &&
                  next_psw[11:10] == 2'b00));

    assert_mask_R10: assert property (@(posedge clk) disable iff (rst)
        take |=> (next_psw[9:6] == 4'hF &&
                  next_psw[4:0] == {1'b0, $past(tgt_el), 2'b01}));

endmodule

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/1ps
module test_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        take;
    logic [63:0] cur_pc;
    logic [31:0] cur_psw;
    logic [1:0]  tgt_el;
    logic [1:0]  exc_kind;
    logic [63:0] vbar;
    logic [63:0] sctlr;
    logic        mte_present;
    logic [63:0] link_pc;
    logic [31:0] saved_psw;
    logic [31:0] next_psw;
    logic [63:0] next_pc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [63:0] e_link, e_pc;
    logic [31:0] e_saved, e_psw;
    bit          e_held;

    always #4 clk = ~clk;

    exc_entry_unit i_exc_entry_unit (
        .clk(clk), .rst(rst), .take(take), .cur_pc(cur_pc), .cur_psw(cur_psw),
        .tgt_el(tgt_el), .exc_kind(exc_kind), .vbar(vbar), .sctlr(sctlr),
        .mte_present(mte_present), .link_pc(link_pc), .saved_psw(saved_psw),
        .next_psw(next_psw), .next_pc(next_pc)
    );

    function automatic logic [63:0] model_pc(logic [31:0] p, logic [1:0] el,
                                             logic [1:0] k, logic [63:0] base);
        int grp;
        bit same_upper;
        same_upper = (p[4] == 1'b0) && (p[3:2] == el) && (p[1] == 1'b0);
        if (same_upper && p[0]) grp = 'h200;
        else if (same_upper) grp = 'h000;
        else if (p[4] == 1'b0) grp = 'h400;
        else grp = 'h600;
        return base + 64'(grp) + 64'(int'(k) * 'h80);
    endfunction

    function automatic logic [31:0] model_psw(logic [31:0] p, logic [63:0] sc,
                                              logic mte, logic [1:0] el);
        logic [31:0] r;
        r = '0;
        r[31:28] = p[31:28];
        r[24]    = p[24];
        r[25]    = mte;
        r[22]    = p[22] | ~sc[23];
        r[12]    = sc[44];
        r[9:6]   = 4'hF;
        r[3:0]   = {el, 2'b01};
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            e_link <= '0; e_saved <= '0; e_psw <= '0; e_pc <= '0;
            e_held <= 1'b0;
        end else begin
            e_held <= !take;
            if (take) begin
                e_link  <= cur_pc;
                e_saved <= cur_psw;
                e_pc    <= model_pc(cur_psw, tgt_el, exc_kind, vbar);
                e_psw   <= model_psw(cur_psw, sctlr, mte_present, tgt_el);
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (e_held) begin
            chk("R2 link", link_pc, e_link);
            chk("R2 saved", 64'(saved_psw), 64'(e_saved));
            chk("R2 psw", 64'(next_psw), 64'(e_psw));
            chk("R2 pc", next_pc, e_pc);
        end else begin
            chk("R3 link", link_pc, e_link);
            chk("R3 saved", 64'(saved_psw), 64'(e_saved));
            chk("R4/R5 pc", next_pc, e_pc);
            chk("R6 flags", 64'(next_psw & 32'hF100_0000), 64'(e_psw & 32'hF100_0000));
            chk("R7 tco", 64'(next_psw[25]), 64'(e_psw[25]));
            chk("R8 pan", 64'(next_psw[22]), 64'(e_psw[22]));
            chk("R9 other", 64'(next_psw & 32'h0CBF_FC20), 64'(e_psw & 32'h0CBF_FC20));
            chk("R10 mask/mode", 64'(next_psw[9:0]), 64'(e_psw[9:0]));
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic drive(logic t, logic [31:0] p, logic [1:0] el, logic [1:0] k,
                         logic [63:0] sc, logic m);
        take = t; cur_psw = p; tgt_el = el; exc_kind = k; sctlr = sc; mte_present = m;
        cur_pc = {$urandom, $urandom};
        vbar = {$urandom, $urandom} & ~64'h7FF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b1, 32'hFFFF_FFFF, 2'd1, 2'd3, '1, 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        take = 1'b0;
        @(negedge clk);
        // R1: cleared after reset
        chk("R1 link", link_pc, 64'd0);
        chk("R1 saved", 64'(saved_psw), 64'd0);
        chk("R1 psw", 64'(next_psw), 64'd0);
        chk("R1 pc", next_pc, 64'd0);

        // R4 groups with each kind (R5), target level 1
        for (int k = 0; k < 4; k++) begin
            drive(1'b1, 32'h0000_0005, 2'd1, 2'(k), 64'h0, 1'b0); tick();
            drive(1'b1, 32'h0000_0004, 2'd1, 2'(k), 64'h0, 1'b1); tick();
            drive(1'b1, 32'h0000_0000, 2'd1, 2'(k), 64'h0, 1'b0); tick();
            drive(1'b1, 32'h0000_0010, 2'd1, 2'(k), 64'h0, 1'b1); tick();
        end
        // R8 SPAN set, PAN clear stays clear; R9 named fields cleared
        drive(1'b1, 32'hFFFF_FFE5 & ~32'h0040_0000, 2'd2, 2'd0,
              64'h0000_1000_0080_0000, 1'b0); tick();
        drive(1'b1, 32'hFFFF_FFFF, 2'd2, 2'd1, 64'h0, 1'b1); tick();
        drive(1'b0, 32'h1234_5678, 2'd3, 2'd2, '1, 1'b0); tick();
        tick();

        // Random mix of takes and holds
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] p;
            logic [1:0]  el;
            el = 2'(1 + $urandom % 3);
            p  = $urandom;
            case ($urandom % 4)
                0: p[4:0] = {1'b0, el, 2'b01};
                1: p[4:0] = {1'b0, el, 2'b00};
                default: ;
            endcase
            drive(1'($urandom % 2), p, el, 2'($urandom), {$urandom, $urandom},
                  1'($urandom));
            tick();
        end

        // Back-to-back nested entries fed from the outputs
        drive(1'b1, 32'h0000_0000, 2'd1, 2'd0, 64'h0, 1'b0); tick();
        for (int n = 0; n < 300; n++) begin
            take = 1'b1;
            cur_psw = next_psw;
            cur_pc = next_pc;
            if ($urandom % 8 == 0) tgt_el = 2'(1 + $urandom % 3);
            exc_kind = 2'($urandom);
            sctlr = {$urandom, $urandom};
            mte_present = 1'($urandom);
            vbar = {$urandom, $urandom} & ~64'h7FF;
            tick();
        end
        take = 1'b0;
        tick();

        done = 1;
        summary();
        $finish;
    end
endmodule